// File: doc/BRIEF.md
# Synchronous Half-Duplex Shift Serial Port

This block is a master-only synchronous serial port. It uses one bidirectional data line and one shift-clock output. The port always generates the shift clock itself, whichever way the data moves. Writing a byte into the port starts an 8-bit transmit on the shared line. When receive is enabled and the receive flag is clear, the port clocks in an 8-bit byte from an external device instead.

Each bit period lasts 12 system clocks or 4 system clocks, chosen by a divide-select input. A transmitted bit is placed on the line one system clock before the shift clock falls, so the far device can latch it on the following rising edge. An incoming bit is captured at the rising edge of the shift clock. Once a byte has been received, the port stops receiving until software clears the receive flag. The received byte can be read on the read-data port.

Top module: `ssp_master`

## Requirements
- R1: Between transfers the shift clock is high and the data-pin output enable is low.
- R2: Each transfer moves 8 bits, least significant bit first, in both directions.
- R3: A bit period is 12 system clocks when `div_sel` is 0 and 4 when it is 1. The value of `div_sel` is taken at the start of the transfer. In every bit period the clock is low for the first half and high for the second half.
- R4: A `buf_wr` pulse while idle starts a transmit of `wr_data`. Bit 0 is driven for one lead cycle with the clock still high. After that, each later bit appears on `sd_o` exactly one system clock before a falling edge of `sclk`, and `sd_o` never changes at a falling edge.
- R5: `sd_oe` is 1 only while a transmit is in progress, from the lead cycle to the end of the eighth bit period.
- R6: `tx_flag` becomes 1 at the end of the eighth transmit bit period. It stays 1 until `tx_flag_clr` is pulsed. If the flag is set and cleared in the same cycle, the set wins.
- R7: A receive starts when the port is idle, `rx_en` is 1 and `rx_flag` is 0. `sd_i` is sampled at each rising edge of `sclk`. One system clock after the eighth rising edge, `rd_data` holds the byte and `rx_flag` becomes 1.
- R8: While `rx_flag` is 1, no receive is started and `sclk` stays high. After `rx_flag_clr`, the next receive can start.
- R9: A `buf_wr` pulse that arrives during a receive is ignored. No transmit starts and `sd_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_wr | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last received byte |
| rx_en | input | 1 | Receive enable |
| div_sel | input | 1 | 0 selects divide by 12, 1 selects divide by 4 |
| tx_flag_clr | input | 1 | Clears the transmit-done flag |
| rx_flag_clr | input | 1 | Clears the receive flag |
| tx_flag | output | 1 | Transmit-done flag |
| rx_flag | output | 1 | Receive-full flag |
| sd_i | input | 1 | Data line as read from the pad |
| sd_o | output | 1 | Data line drive value |
| sd_oe | output | 1 | Data line output enable |
| sclk | output | 1 | Shift clock output |

## Verification
The bench transmits bytes with alternating patterns, such as 0xA5, and with runs, such as 0x3C. It does this at both divide settings, so a reversed bit order, a wrong half-period split or a misplaced data update shows up on a specific cycle.

For receive, the bench drives 0x96 and 0x5B. It toggles the idle line in between so that any sample taken outside the rising edge corrupts the byte. It then holds the flag set for a long time to show that reception has stalled.

It also writes the buffer in the middle of a receive and transmits a single-bit byte afterwards. This separates a write that was ignored from one that was queued or one that interrupted the receive.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_SHIFT = 2'd2
  } ssp_phase_e;

  // Bit period in system clocks for the selected divide mode.
  function automatic int unsigned bit_period(input logic fast,
                                             input int unsigned slow_div,
                                             input int unsigned fast_div);
    return fast ? fast_div : slow_div;
  endfunction

  // Number of clocks the shift clock is low at the start of a period.
  function automatic int unsigned low_span(input int unsigned period);
    return period / 2;
  endfunction

endpackage

// File: rtl/ssp_bit_timer.sv
module ssp_bit_timer #(
  parameter int CW    = 4,
  parameter int BW    = 3,
  parameter int NBITS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic [CW-1:0] per,
  output logic [CW-1:0] cnt,
  output logic [BW-1:0] bidx,
  output logic          last_bit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bidx <= '0;
    end else if (start) begin
      cnt  <= '0;
      bidx <= '0;
    end else if (run) begin
      if (cnt == per - CW'(1)) begin
        cnt  <= '0;
        bidx <= bidx + BW'(1);
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign last_bit = (bidx == BW'(NBITS - 1));

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_tx,
  input  logic         sample,
  input  logic         sd_i,
  input  logic         commit,
  output logic         tx_bit,
  output logic [W-1:0] rx_buf
);

  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (load) begin
      sh <= load_val;
    end else if (shift_tx) begin
      sh <= sh >> 1;
    end else if (sample) begin
      sh <= {sd_i, sh[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_buf <= '0;
    else if (commit) rx_buf <= sh;
  end

  assign tx_bit = sh[0];

endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_en,
  input  logic              div_sel,
  input  logic              tx_flag_clr,
  input  logic              rx_flag_clr,
  output logic              tx_flag,
  output logic              rx_flag,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe,
  output logic              sclk
);

  localparam int CW = $clog2(SLOW_DIV + 1);
  localparam int BW = $clog2(DATA_W);

  ssp_phase_e    ph;
  logic          is_tx;
  logic [CW-1:0] per_q;
  logic [CW-1:0] half;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic          last_bit;
  logic          tx_flag_q, rx_flag_q;

  // Named internal events, also observed by the checker.
  logic ph_idle, shifting, start_tx, start_rx, tmr_start;
  logic present_ev, tx_done_ev, sample_ev, rx_done_ev;
  logic rx_active, tx_bit;

  assign ph_idle    = (ph == PH_IDLE);
  assign shifting   = (ph == PH_SHIFT);
  assign half       = CW'(low_span(int'(per_q)));
  assign start_tx   = ph_idle && buf_wr;
  assign start_rx   = ph_idle && !buf_wr && rx_en && !rx_flag_q;
  assign tmr_start  = (ph == PH_LEAD) || start_rx;
  assign rx_active  = shifting && !is_tx;
  assign present_ev = shifting && is_tx && !last_bit && (cnt == per_q - CW'(2));
  assign tx_done_ev = shifting && is_tx && last_bit && (cnt == per_q - CW'(1));
  assign sample_ev  = rx_active && (cnt == half - CW'(1));
  assign rx_done_ev = rx_active && last_bit && (cnt == half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      is_tx <= 1'b0;
      per_q <= CW'(SLOW_DIV);
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (start_tx || start_rx) begin
            ph    <= start_tx ? PH_LEAD : PH_SHIFT;
            is_tx <= start_tx;
            per_q <= CW'(bit_period(div_sel, SLOW_DIV, FAST_DIV));
          end
        end
        PH_LEAD:  ph <= PH_SHIFT;
        PH_SHIFT: if (tx_done_ev || rx_done_ev) ph <= PH_IDLE;
        default:  ph <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_flag_q <= 1'b0;
      rx_flag_q <= 1'b0;
    end else begin
      if (tx_done_ev)       tx_flag_q <= 1'b1;
      else if (tx_flag_clr) tx_flag_q <= 1'b0;
      if (rx_done_ev)       rx_flag_q <= 1'b1;
      else if (rx_flag_clr) rx_flag_q <= 1'b0;
    end
  end

  ssp_bit_timer #(.CW(CW), .BW(BW), .NBITS(DATA_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tmr_start),
    .run      (shifting),
    .per      (per_q),
    .cnt      (cnt),
    .bidx     (bidx),
    .last_bit (last_bit)
  );

  ssp_shifter #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_tx),
    .load_val (wr_data),
    .shift_tx (present_ev),
    .sample   (sample_ev),
    .sd_i     (sd_i),
    .commit   (rx_done_ev),
    .tx_bit   (tx_bit),
    .rx_buf   (rd_data)
  );

  assign sclk    = !(shifting && (cnt < half));
  assign sd_oe   = is_tx && !ph_idle;
  assign sd_o    = tx_bit;
  assign tx_flag = tx_flag_q;
  assign rx_flag = rx_flag_q;

endmodule

// File: rtl/ssp_master_chk.sv
module ssp_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sd_oe,
  input logic sd_o,
  input logic tx_flag,
  input logic rx_flag,
  input logic buf_wr,
  input logic ph_idle,
  input logic rx_active,
  input logic tx_done_ev
);

  // R1: idle means clock high and pin released
  p_idle_clk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ph_idle |-> (sclk && !sd_oe));

  // R4: transmit data is never changing at a falling clock edge
  p_data_held_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && sd_oe && $past(sd_oe)) |-> $stable(sd_o));

  // R5: output enable never overlaps a receive
  p_oe_tx_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> !rx_active);

  // R6: transmit flag rises only after the final bit period ends
  p_txflag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> $past(tx_done_ev));

  // R7: receive flag rises one clock after a rising shift-clock edge
  p_rxflag_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> ($past(sclk) && !$past(sclk, 2)));

  // R8: no receive runs while the flag is set
  p_no_rx_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |-> !rx_active);

  // R9: a write during receive does not start a transmit
  p_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && buf_wr) |=> !sd_oe);

endmodule

bind ssp_master ssp_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk       (sclk),
  .sd_oe      (sd_oe),
  .sd_o       (sd_o),
  .tx_flag    (tx_flag),
  .rx_flag    (rx_flag),
  .buf_wr     (buf_wr),
  .ph_idle    (ph_idle),
  .rx_active  (rx_active),
  .tx_done_ev (tx_done_ev)
);

// File: tb/test_ssp_master.sv
module test_ssp_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buf_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rx_en = 1'b0;
  logic       div_sel = 1'b0;
  logic       tx_flag_clr = 1'b0;
  logic       rx_flag_clr = 1'b0;
  logic       tx_flag, rx_flag;
  logic       sd_i = 1'b1;
  logic       sd_o, sd_oe, sclk;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ssp_master i_ssp_master (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .wr_data(wr_data),
    .rd_data(rd_data), .rx_en(rx_en), .div_sel(div_sel),
    .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
    .tx_flag(tx_flag), .rx_flag(rx_flag), .sd_i(sd_i),
    .sd_o(sd_o), .sd_oe(sd_oe), .sclk(sclk)
  );

  // Reference model: 0 idle, 1 transmit, 2 receive; m_t counts cycles in transfer
  int       m_mode = 0, m_t = 0, m_n = 12;
  bit [7:0] m_txd = 0, m_acc = 0, m_buf = 0;
  bit       m_tf = 0, m_rf = 0;
  bit [7:0] ext_byte = 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit ts, rs;
    ts = 0; rs = 0;
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_tf = 0; m_rf = 0; m_buf = 0;
    end else begin
      case (m_mode)
        0: if (buf_wr) begin
             m_mode = 1; m_t = 0; m_n = div_sel ? 4 : 12; m_txd = wr_data;
           end else if (rx_en && !m_rf) begin
             m_mode = 2; m_t = 0; m_n = div_sel ? 4 : 12;
           end
        1: if (m_t == 8 * m_n) begin m_mode = 0; ts = 1; end
           else m_t++;
        default: begin
          if (m_t % m_n == m_n / 2 - 1) m_acc[m_t / m_n] = sd_i;
          if (m_t == 7 * m_n + m_n / 2) begin
            m_buf = m_acc; rs = 1; m_mode = 0;
          end else m_t++;
        end
      endcase
      m_tf = ts ? 1'b1 : (tx_flag_clr ? 1'b0 : m_tf);
      m_rf = rs ? 1'b1 : (rx_flag_clr ? 1'b0 : m_rf);
    end
  end

  // External device: drives the receive byte, toggles the line otherwise
  always @(negedge clk) begin
    if (m_mode == 2) sd_i <= ext_byte[(m_t / m_n) % 8];
    else sd_i <= ~sd_i;
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_clk, exp_oe, exp_d;
      int u, b, ph, idx;
      exp_clk = 1; exp_oe = (m_mode == 1); exp_d = 0;
      if (m_mode == 1) begin
        if (m_t == 0) exp_d = m_txd[0];
        else begin
          u = m_t - 1; b = u / m_n; ph = u % m_n;
          exp_clk = (ph >= m_n / 2);
          idx = (ph == m_n - 1 && b < 7) ? b + 1 : b;
          exp_d = m_txd[idx];
        end
      end else if (m_mode == 2) begin
        exp_clk = ((m_t % m_n) >= m_n / 2);
      end
      chk(sclk == exp_clk, "R3 sclk", sclk, exp_clk);
      chk(sd_oe == exp_oe, "R5 sd_oe", sd_oe, exp_oe);
      if (exp_oe) chk(sd_o == exp_d, "R4 sd_o", sd_o, exp_d);
      chk(tx_flag == m_tf, "R6 tx_flag", tx_flag, m_tf);
      chk(rx_flag == m_rf, "R7 rx_flag", rx_flag, m_rf);
      chk(rd_data == m_buf, "R2 rd_data", rd_data, m_buf);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input bit [7:0] d);
    @(negedge clk); wr_data = d; buf_wr = 1;
    @(negedge clk); buf_wr = 0;
  endtask

  task automatic clear_tx();
    @(negedge clk); tx_flag_clr = 1;
    @(negedge clk); tx_flag_clr = 0;
  endtask

  task automatic clear_rx();
    @(negedge clk); rx_flag_clr = 1;
    @(negedge clk); rx_flag_clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    cycles(4);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(sclk == 1 && sd_oe == 0, "R1 idle pins", {sclk, sd_oe}, 2'b10);
    chk(tx_flag == 0 && rx_flag == 0 && rd_data == 0, "R1 reset flags",
        {tx_flag, rx_flag, rd_data}, 0);

    // Slow transmit of an alternating pattern
    div_sel = 0;
    write_byte(8'hA5);
    cycles(110);
    chk(tx_flag == 1, "R6 flag after slow transmit", tx_flag, 1);
    chk(sd_oe == 0 && sclk == 1, "R1 idle after transmit", {sd_oe, sclk}, 2'b01);
    clear_tx();

    // Fast transmit of a run pattern
    div_sel = 1;
    write_byte(8'h3C);
    cycles(45);
    clear_tx();

    // Slow receive
    ext_byte = 8'h96;
    div_sel = 0;
    @(negedge clk); rx_en = 1;
    cycles(100);
    chk(rd_data == 8'h96 && rx_flag == 1, "R7 received byte", rd_data, 8'h96);
    // R8: stall while the flag is held
    cycles(60);
    chk(sclk == 1 && rx_flag == 1 && rd_data == 8'h96, "R8 stalled",
        {sclk, rx_flag}, 2'b11);

    // Fast receive after clearing, with a write in the middle (R9)
    ext_byte = 8'h5B;
    div_sel = 1;
    clear_rx();
    cycles(4);
    write_byte(8'hFF);
    chk(sd_oe == 0, "R9 write ignored during receive", sd_oe, 0);
    cycles(40);
    chk(rd_data == 8'h5B, "R2 fast received byte", rd_data, 8'h5B);
    chk(tx_flag == 0 && sd_oe == 0, "R9 no transmit started", {tx_flag, sd_oe}, 0);

    rx_en = 0;
    clear_rx();
    cycles(5);
    write_byte(8'h01);
    cycles(45);
    chk(tx_flag == 1, "R6 flag after single-bit byte", tx_flag, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule